// File: doc/BRIEF.md
# Fully Associative Word Cache

This block sits between a requester and a slower main memory. It keeps a small set of entries. Each entry holds one 12-bit data word and the complete 15-bit memory address of that word. Because the whole address serves as the tag, any entry can hold any word. When a read request is accepted, its address goes into an argument register. That register is then compared against every valid stored address at the same time.

On a match, the stored word is returned one cycle after acceptance and main memory is not touched. On no match, the block drives a read to the memory port and holds it until the word comes back. It passes that word to the requester in the same cycle and installs the address/data pair. Empty entries are filled first. Once every entry is valid, the oldest fill is evicted in round-robin order. Two counters record completed hits and completed misses.

Top module: `assoc_word_cache`

## Requirements
- R1: After reset every entry is invalid, both counters read zero, req_ready is high, and rsp_valid and mem_req are low; the first request after reset always misses.
- R2: A request is taken only in a cycle where req_valid and req_ready are both high; req_ready is low from acceptance until the response cycle has passed, and req_valid or req_addr driven meanwhile change neither mem_addr, the response nor the counters.
- R3: When the latched address equals the address of a valid entry, rsp_valid and rsp_hit are high in the first cycle after acceptance, rsp_data is that entry's word, and mem_req stays low.
- R4: On a miss, mem_req is high with mem_addr equal to the request address from the first cycle after acceptance until the cycle where mem_rsp_valid is seen; in that cycle rsp_valid is high, rsp_hit is low and rsp_data equals mem_rsp_data.
- R5: A completed miss installs the address/data pair, so a later request for the same address hits with that word as long as the entry has not been evicted.
- R6: A fill uses the lowest-numbered invalid entry; when all entries are valid it evicts the entry at a round-robin pointer that starts at entry 0 and advances by one, wrapping, after each evicting fill.
- R7: hit_count increases by exactly one per hit response and miss_count by exactly one per miss response, both wrapping modulo 2^CNT_W.
- R8: The comparison uses all 15 address bits, so addresses that differ only in the top bit occupy separate entries and never match each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request present |
| req_addr | input | 15 | Word address of the request |
| req_ready | output | 1 | Block can take a request this cycle |
| rsp_valid | output | 1 | Response word present (one cycle) |
| rsp_hit | output | 1 | Response served from a stored entry |
| rsp_data | output | 12 | Returned data word |
| mem_req | output | 1 | Main-memory read pending |
| mem_addr | output | 15 | Main-memory read address |
| mem_rsp_valid | input | 1 | Main-memory word available |
| mem_rsp_data | input | 12 | Main-memory data word |
| hit_count | output | 16 | Completed hits |
| miss_count | output | 16 | Completed misses |

## Verification
A wrong tag, a wrong data word or a stuck valid bit appears at the ports on the next request for that address. It shows either as a hit that should be a miss, seen through mem_req one cycle after acceptance, or as a wrong rsp_data. A faulty replacement pointer is caught later, on the first re-request of an address that the reference model expects to be resident or evicted, which can be several requests after the faulty fill. Counter faults show in the cycle after the response completes.

// File: rtl/assoc_cache_pkg.sv
package assoc_cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_FETCH  = 2'd2
  } cache_state_t;

  // advance a round-robin index with wrap at n
  function automatic int wrap_inc(int p, int n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction

  // lowest position holding a zero; returns 0 when none
  function automatic int lowest_zero(logic [255:0] vec, int n);
    int r;
    r = 0;
    for (int i = n - 1; i >= 0; i--) begin
      if (!vec[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/entry_store.sv
module entry_store #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 12,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [ADDR_W-1:0] tags  [ENTRIES],
  output logic [DATA_W-1:0] datas [ENTRIES]
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_vec[g] <= 1'b0;
        tags[g]      <= '0;
        datas[g]     <= '0;
      end else if (sel) begin
        valid_vec[g] <= 1'b1;
        tags[g]      <= wr_addr;
        datas[g]     <= wr_data;
      end
    end
  end

  // R1: a valid bit only rises through a write to that entry
  p_valid_needs_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en)) |-> (valid_vec == $past(valid_vec)));

endmodule

// File: rtl/cam_match.sv
module cam_match #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] key,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ADDR_W-1:0] tags  [ENTRIES],
  input  logic [DATA_W-1:0] datas [ENTRIES],
  output logic [ENTRIES-1:0] hit_vec,
  output logic              any_hit,
  output logic [DATA_W-1:0] hit_data
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid_vec[g] && (tags[g] == key);
  end

  assign any_hit = |hit_vec;

  always_comb begin
    hit_data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_data = hit_data | datas[i];
    end
  end

  // R8: a stored address is never present twice
  p_single_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

endmodule

// File: rtl/victim_select.sv
module victim_select
  import assoc_cache_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               fill_en,
  output logic [IDX_W-1:0]   victim_idx
);

  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] free_idx;
  logic             all_valid;
  logic [255:0]     vec_wide;

  assign all_valid = &valid_vec;

  always_comb begin
    vec_wide = '1;
    vec_wide[ENTRIES-1:0] = valid_vec;
    free_idx = IDX_W'(lowest_zero(vec_wide, ENTRIES));
  end

  assign victim_idx = all_valid ? rr_ptr : free_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_ptr <= '0;
    else if (fill_en && all_valid)
      rr_ptr <= IDX_W'(wrap_inc(int'(rr_ptr), ENTRIES));
  end

  // R6: while a free entry exists, the fill never overwrites a valid one
  p_fill_prefers_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !all_valid) |-> !valid_vec[victim_idx]);

endmodule

// File: rtl/assoc_word_cache.sv
module assoc_word_cache
  import assoc_cache_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 12,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  cache_state_t      state;
  logic [ADDR_W-1:0] arg_addr;
  logic              accept;
  logic              hit_done;
  logic              fill_en;

  logic [ENTRIES-1:0] valid_vec;
  logic [ADDR_W-1:0]  tags  [ENTRIES];
  logic [DATA_W-1:0]  datas [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;
  logic               any_hit;
  logic [DATA_W-1:0]  hit_data;
  logic [IDX_W-1:0]   victim_idx;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign hit_done  = (state == ST_LOOKUP) && any_hit;
  assign mem_req   = ((state == ST_LOOKUP) && !any_hit) || (state == ST_FETCH);
  assign mem_addr  = arg_addr;
  assign fill_en   = mem_req && mem_rsp_valid;

  assign rsp_valid = hit_done || fill_en;
  assign rsp_hit   = hit_done;
  assign rsp_data  = hit_done ? hit_data : mem_rsp_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      arg_addr <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          arg_addr <= req_addr;
          state    <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          if (any_hit || mem_rsp_valid) state <= ST_IDLE;
          else                          state <= ST_FETCH;
        end
        ST_FETCH: if (mem_rsp_valid) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      if (hit_done) hit_count  <= hit_count + 1'b1;
      if (fill_en)  miss_count <= miss_count + 1'b1;
    end
  end

  entry_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(fill_en), .wr_idx(victim_idx),
    .wr_addr(arg_addr), .wr_data(mem_rsp_data),
    .valid_vec(valid_vec), .tags(tags), .datas(datas)
  );

  cam_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cam (
    .clk(clk), .rst_n(rst_n),
    .key(arg_addr), .valid_vec(valid_vec), .tags(tags), .datas(datas),
    .hit_vec(hit_vec), .any_hit(any_hit), .hit_data(hit_data)
  );

  victim_select #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n),
    .valid_vec(valid_vec), .fill_en(fill_en), .victim_idx(victim_idx)
  );

  // R2: one response then back to accepting
  p_ready_after_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready);

  // R4: the memory read is held with a steady address until answered
  p_fetch_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_addr)));

  // R5: the filled entry carries the requested address afterwards
  p_fill_installs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (valid_vec[$past(victim_idx)] && tags[$past(victim_idx)] == $past(arg_addr)));

  // R3: a hit never coexists with a memory read
  p_hit_no_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> !mem_req);

  // R7: the two counters together step by at most one per cycle
  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (CNT_W'(hit_count + miss_count - $past(hit_count) - $past(miss_count)) <= 1));

endmodule

// File: tb/assoc_word_cache_test.sv
module assoc_word_cache_test;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [14:0] req_addr;
  logic        req_ready;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [11:0] rsp_data;
  logic        mem_req;
  logic [14:0] mem_addr;
  logic        mem_rsp_valid;
  logic [11:0] mem_rsp_data;
  logic [15:0] hit_count;
  logic [15:0] miss_count;

  always #2 clk = ~clk;

  assoc_word_cache uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_data(rsp_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit          m_valid [N];
  logic [14:0] m_tag   [N];
  logic [11:0] m_data  [N];
  int          m_ptr;
  int          exp_hits;
  int          exp_miss;

  function automatic logic [11:0] mem_word(logic [14:0] a);
    return 12'((a * 7) ^ (a >> 3) ^ 15'h05a3);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic do_req(logic [14:0] a, int lat);
    int  idx;
    int  vic;
    bit  hit;
    bit  full;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    hit = 0; idx = 0;
    for (int i = 0; i < N; i++)
      if (m_valid[i] && m_tag[i] == a) begin hit = 1; idx = i; end
    if (hit) begin
      chk(rsp_valid && rsp_hit, "R3 hit response", {rsp_valid, rsp_hit}, 3);
      chk(rsp_data == m_data[idx], "R3 R5 hit data", rsp_data, m_data[idx]);
      chk(!mem_req, "R3 no memory read on hit", mem_req, 0);
      exp_hits++;
      @(posedge clk);
      @(negedge clk);
    end else begin
      chk(mem_req && mem_addr == a, "R4 R6 miss read issued", mem_addr, a);
      chk(!rsp_valid, "R4 no early response", rsp_valid, 0);
      for (int k = 0; k < lat; k++) begin
        req_valid = 1'b1;
        req_addr  = a ^ 15'h0011;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_req && mem_addr == a && !req_ready, "R2 R4 read held, busy",
            mem_addr, a);
      end
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem_word(a);
      #1;
      chk(rsp_valid && !rsp_hit && rsp_data == mem_word(a), "R4 miss response",
          rsp_data, mem_word(a));
      @(posedge clk);
      full = 1; vic = 0;
      for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) begin full = 0; vic = i; end
      if (full) begin vic = m_ptr; m_ptr = (m_ptr + 1) % N; end
      m_valid[vic] = 1; m_tag[vic] = a; m_data[vic] = mem_word(a);
      exp_miss++;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
    end
    chk(hit_count == 16'(exp_hits), "R7 hit count", hit_count, exp_hits);
    chk(miss_count == 16'(exp_miss), "R7 R2 miss count", miss_count, exp_miss);
    chk(req_ready && !rsp_valid, "R2 ready after response", req_ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    finish_run();
  end

  initial begin
    logic [14:0] pool [14];
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) m_valid[i] = 0;
    m_ptr = 0; exp_hits = 0; exp_miss = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0;
    mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req, "R1 reset outputs", req_ready, 1);
    chk(hit_count == 0 && miss_count == 0, "R1 counters zero", hit_count, 0);

    // R1: first access misses; R5 refetch hits; R8 top-bit alias
    do_req(15'h1234, 2);
    do_req(15'h1234, 0);
    do_req(15'h5234, 0);
    do_req(15'h1234, 1);
    do_req(15'h5234, 3);
    // R6: fill every entry, then evict in FIFO order
    for (int i = 0; i < N + 3; i++) do_req(15'h0100 + 15'(i), i % 3);
    do_req(15'h1234, 1);
    do_req(15'h0100 + 15'(N - 1), 0);

    for (int i = 0; i < 14; i++)
      pool[i] = (i % 2 == 1) ? (15'h4000 | 15'(i * 37)) : 15'(i * 37);
    for (int n = 0; n < 400; n++)
      do_req(pool[$urandom_range(0, 13)], $urandom_range(0, 3));

    finish_run();
  end
endmodule